// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged control registers that a processor core reaches through a numbered move-to-control and move-from-control operation. The core presents a 12-bit register number, the direction of the transfer, the 32-bit value to be written and the processor model currently emulated. For a legal read the block returns the stored value. For a legal write it stores the value through a per-register mask. When the number is not defined for the selected model, the block raises an illegal flag, which the core turns into an illegal-instruction trap.

Two entries are stack pointers: the master stack pointer and the interrupt stack pointer. One of them is the live A7, chosen by the core's master-mode bit. The core feeds the live A7 in, and for that entry a read returns the live A7 rather than the stored copy. A write to that entry stores the copy and also drives a load strobe that updates A7 in the core's register file.

Decode of the instruction, privilege checks and any cache or translation behaviour behind the stored values belong to the core.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset every stored register reads as zero.
- R2: Number 0x000 (source code space) and number 0x001 (destination code space) keep only bits [2:0] of the written value.
- R3: Number 0x002 (cache control) keeps the bits under mask 0x00000003 when the model selector `cpuModel` is below 4, and under mask 0x80008000 when it is 4 or above.
- R4: Number 0x003 (translation control) keeps the bits under mask 0x0000C000. Numbers 0x004 and 0x005 (the two instruction transparent windows) keep the bits under mask 0xFFFFE364.
- R5: Number 0x802 (cache address) keeps the bits under mask 0x000000FC.
- R6: A legal write to 0x803 (master stack pointer) while `masterMode`=1, or to 0x804 (interrupt stack pointer) while `masterMode`=0, stores the value and, in the same cycle, raises `a7Load` with `a7Value` equal to `wrData`. A write to the other stack pointer stores the value and leaves `a7Load` low.
- R7: A legal read of 0x803 returns `a7Live` when `masterMode`=1 and the stored copy otherwise. A legal read of 0x804 returns `a7Live` when `masterMode`=0 and the stored copy otherwise.
- R8: Numbers 0x805, 0x806 and 0x807 (translation status, user root pointer and supervisor root pointer) store and return all 32 bits.
- R9: An access is illegal when `cpuModel`=1 and `regNum[10:0]` > 1, when `cpuModel` < 4 and `regNum[10:0]` > 2, or when `cpuModel`=4 and `regNum`=0x802. Models 0, 2, 3 and 5 to 7 are otherwise unrestricted by this rule.
- R10: Any number outside {0x000 to 0x005, 0x802 to 0x807} is illegal on every model.
- R11: An illegal access (`accEn`=1) raises `illegal` in the same cycle, leaves every stored register unchanged, returns `rdData`=0 and keeps `a7Load` low.
- R12: While `accEn`=0, `illegal` and `a7Load` are low and no register changes. `rdData` is 0 whenever no legal read is in progress. A write is `accWrite`=1 and a read is `accWrite`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, writes commit on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| accEn | input | 1 | An access is presented this cycle |
| accWrite | input | 1 | 1 = move to register, 0 = move from register |
| regNum | input | 12 | Control register number |
| wrData | input | 32 | Value to write |
| cpuModel | input | 3 | Processor model selector |
| masterMode | input | 1 | Master-mode bit of the status register |
| a7Live | input | 32 | Current A7 of the core |
| rdData | output | 32 | Read value, combinational |
| illegal | output | 1 | Access is illegal, trap required |
| a7Load | output | 1 | Load A7 from `a7Value` this cycle |
| a7Value | output | 32 | New A7 value |

## Verification
The properties assume that `accEn`, `accWrite`, `regNum`, `cpuModel` and `masterMode` are stable for the whole cycle in which an access is presented, and that `a7Live` reflects any earlier `a7Load`. The bench changes inputs only on the falling edge and holds them through the next rising edge. It also feeds `a7Live` explicitly, so every alias read has a known expected value and does not depend on a core model looping `a7Value` back.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_W  = 12;

  typedef enum int {
    IX_SFC = 0, IX_DFC, IX_CACR, IX_TC, IX_ITT0, IX_ITT1,
    IX_CAAR, IX_MSP, IX_ISP, IX_MMUSR, IX_URP, IX_SRP, IX_COUNT
  } regIdx_e;

  localparam int NREG = IX_COUNT;

  typedef struct packed {
    logic [NREG-1:0] wrSel;     // one-hot write enable
    logic [NREG-1:0] rdSel;     // one-hot read select
    logic            cacrWide;  // wide cache-control mask
    logic            aliasRead; // read returns live A7
    logic            a7Load;    // write also loads A7
  } ctrlStb_t;

  function automatic logic [DATA_W-1:0] regMask(input int idx, input logic wide);
    case (idx)
      IX_SFC, IX_DFC:   regMask = 32'h0000_0007;
      IX_CACR:          regMask = wide ? 32'h8000_8000 : 32'h0000_0003;
      IX_TC:            regMask = 32'h0000_C000;
      IX_ITT0, IX_ITT1: regMask = 32'hFFFF_E364;
      IX_CAAR:          regMask = 32'h0000_00FC;
      default:          regMask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/ctrl_reg_decode.sv
module ctrl_reg_decode
  import ctrl_reg_pkg::*;
#(
  parameter int MODEL_W = 3
) (
  input  logic               accEn,
  input  logic               accWrite,
  input  logic [NUM_W-1:0]   regNum,
  input  logic [MODEL_W-1:0] cpuModel,
  input  logic               masterMode,
  output ctrlStb_t           stb,
  output logic               illegal
);
  localparam int LOW_W = NUM_W - 1;

  logic            hit;
  int              idx;
  logic            modelBad;
  logic            legal;
  logic [LOW_W-1:0] lowNum;
  logic [NREG-1:0] oneHot;
  logic            isActiveSp;

  assign lowNum = regNum[LOW_W-1:0];

  always_comb begin
    hit = 1'b1;
    idx = IX_SFC;
    case (regNum)
      12'h000: idx = IX_SFC;
      12'h001: idx = IX_DFC;
      12'h002: idx = IX_CACR;
      12'h003: idx = IX_TC;
      12'h004: idx = IX_ITT0;
      12'h005: idx = IX_ITT1;
      12'h802: idx = IX_CAAR;
      12'h803: idx = IX_MSP;
      12'h804: idx = IX_ISP;
      12'h805: idx = IX_MMUSR;
      12'h806: idx = IX_URP;
      12'h807: idx = IX_SRP;
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    modelBad = 1'b0;
    if (cpuModel == MODEL_W'(1) && lowNum > LOW_W'(1)) modelBad = 1'b1;
    if (cpuModel <  MODEL_W'(4) && lowNum > LOW_W'(2)) modelBad = 1'b1;
    if (cpuModel == MODEL_W'(4) && regNum == 12'h802)  modelBad = 1'b1;
  end

  assign legal      = hit && !modelBad;
  assign illegal    = accEn && !legal;
  assign oneHot     = hit ? (NREG'(1) << idx) : '0;
  assign isActiveSp = (idx == IX_MSP && masterMode) || (idx == IX_ISP && !masterMode);

  always_comb begin
    stb           = '0;
    stb.cacrWide  = cpuModel >= MODEL_W'(4);
    if (accEn && legal) begin
      if (accWrite) begin
        stb.wrSel  = oneHot;
        stb.a7Load = isActiveSp;
      end else begin
        stb.rdSel     = oneHot;
        stb.aliasRead = isActiveSp;
      end
    end
  end
endmodule

// File: rtl/ctrl_reg_store.sv
module ctrl_reg_store
  import ctrl_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] a7Live,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] regQ   [NREG];
  logic [DATA_W-1:0] rdTerm [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              regQ[g] <= '0;
      else if (stb.wrSel[g])  regQ[g] <= wrData & regMask(g, stb.cacrWide);
    end
    assign rdTerm[g] = stb.rdSel[g] ? regQ[g] : '0;
  end

  always_comb begin
    rdData = '0;
    if (stb.aliasRead) rdData = a7Live;
    else for (int i = 0; i < NREG; i++) rdData = rdData | rdTerm[i];
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import ctrl_reg_pkg::*;
#(
  parameter int MODEL_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accEn,
  input  logic               accWrite,
  input  logic [NUM_W-1:0]   regNum,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [MODEL_W-1:0] cpuModel,
  input  logic               masterMode,
  input  logic [DATA_W-1:0]  a7Live,
  output logic [DATA_W-1:0]  rdData,
  output logic               illegal,
  output logic               a7Load,
  output logic [DATA_W-1:0]  a7Value
);
  ctrlStb_t stb;

  ctrl_reg_decode #(.MODEL_W(MODEL_W)) u_decode (
    .accEn(accEn), .accWrite(accWrite), .regNum(regNum), .cpuModel(cpuModel),
    .masterMode(masterMode), .stb(stb), .illegal(illegal)
  );

  ctrl_reg_store u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .a7Live(a7Live), .rdData(rdData)
  );

  assign a7Load  = stb.a7Load;
  assign a7Value = stb.a7Load ? wrData : '0;
endmodule

// File: rtl/ctrl_reg_bank_chk.sv
module ctrl_reg_bank_chk
  import ctrl_reg_pkg::*;
#(
  parameter int MODEL_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               accEn,
  input logic               accWrite,
  input logic [NUM_W-1:0]   regNum,
  input logic [DATA_W-1:0]  wrData,
  input logic [MODEL_W-1:0] cpuModel,
  input logic               masterMode,
  input logic [DATA_W-1:0]  a7Live,
  input logic [DATA_W-1:0]  rdData,
  input logic               illegal,
  input logic               a7Load,
  input logic [DATA_W-1:0]  a7Value
);
  logic rdOk;
  assign rdOk = accEn && !accWrite && !illegal;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !accEn |-> (!illegal && !a7Load)); // R12
  AST_ILLEGAL_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN) illegal |-> (!a7Load && rdData == '0)); // R11
  AST_A7_VALUE: assert property (@(posedge clk) disable iff (!rstN) a7Load |-> (a7Value == wrData && accWrite)); // R6
  AST_CODE_SPACE_NARROW: assert property (@(posedge clk) disable iff (!rstN) (rdOk && regNum <= 12'h001) |-> rdData[31:3] == '0); // R2
  AST_CAAR_MASK: assert property (@(posedge clk) disable iff (!rstN) (rdOk && regNum == 12'h802) |-> (rdData & ~32'h0000_00FC) == '0); // R5
  AST_MODEL1_LIMIT: assert property (@(posedge clk) disable iff (!rstN) (accEn && cpuModel == MODEL_W'(1) && regNum[10:0] > 11'd1) |-> illegal); // R9
  AST_MSP_ALIAS: assert property (@(posedge clk) disable iff (!rstN) (rdOk && regNum == 12'h803 && masterMode) |-> rdData == a7Live); // R7
  AST_UNLISTED: assert property (@(posedge clk) disable iff (!rstN) (accEn && regNum > 12'h005 && regNum < 12'h802) |-> illegal); // R10
endmodule

bind ctrl_reg_bank ctrl_reg_bank_chk #(.MODEL_W(MODEL_W)) u_chk (.*);

// File: tb/ctrl_reg_bank_tb.sv
module ctrl_reg_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accEn = 1'b0;
  logic        accWrite = 1'b0;
  logic [11:0] regNum = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  cpuModel = 3'd4;
  logic        masterMode = 1'b0;
  logic [31:0] a7Live = '0;
  logic [31:0] rdData;
  logic        illegal;
  logic        a7Load;
  logic [31:0] a7Value;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctrl_reg_bank u_dut (.*);

  typedef struct packed {
    logic        wr;
    logic [2:0]  model;
    logic [11:0] num;
    logic [31:0] data;
    logic        master;
    logic [31:0] a7;
    logic [31:0] expRd;
    logic        expIll;
    logic        expLoad;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VECS [NV] = '{
    '{1'b1,3'd4,12'h000,32'hFFFFFFFF,1'b0,32'h0,32'h0,1'b0,1'b0},        // R2
    '{1'b0,3'd4,12'h000,32'h0,1'b0,32'h0,32'h7,1'b0,1'b0},               // R2
    '{1'b1,3'd4,12'h001,32'h0000000D,1'b0,32'h0,32'h0,1'b0,1'b0},        // R2
    '{1'b0,3'd4,12'h001,32'h0,1'b0,32'h0,32'h5,1'b0,1'b0},               // R2
    '{1'b1,3'd4,12'h002,32'hFFFFFFFF,1'b0,32'h0,32'h0,1'b0,1'b0},        // R3 wide
    '{1'b0,3'd4,12'h002,32'h0,1'b0,32'h0,32'h80008000,1'b0,1'b0},        // R3
    '{1'b1,3'd2,12'h002,32'hFFFFFFFF,1'b0,32'h0,32'h0,1'b0,1'b0},        // R3 narrow
    '{1'b0,3'd2,12'h002,32'h0,1'b0,32'h0,32'h3,1'b0,1'b0},               // R3
    '{1'b1,3'd4,12'h003,32'hFFFFFFFF,1'b0,32'h0,32'h0,1'b0,1'b0},        // R4
    '{1'b0,3'd4,12'h003,32'h0,1'b0,32'h0,32'h0000C000,1'b0,1'b0},        // R4
    '{1'b1,3'd4,12'h004,32'hFFFFFFFF,1'b0,32'h0,32'h0,1'b0,1'b0},        // R4
    '{1'b0,3'd4,12'h004,32'h0,1'b0,32'h0,32'hFFFFE364,1'b0,1'b0},        // R4
    '{1'b1,3'd4,12'h005,32'h12345678,1'b0,32'h0,32'h0,1'b0,1'b0},        // R4
    '{1'b0,3'd4,12'h005,32'h0,1'b0,32'h0,32'h12344260,1'b0,1'b0},        // R4
    '{1'b1,3'd3,12'h802,32'hFFFFFFFF,1'b0,32'h0,32'h0,1'b0,1'b0},        // R5
    '{1'b0,3'd3,12'h802,32'h0,1'b0,32'h0,32'h000000FC,1'b0,1'b0},        // R5
    '{1'b1,3'd4,12'h805,32'hDEADBEEF,1'b0,32'h0,32'h0,1'b0,1'b0},        // R8
    '{1'b1,3'd4,12'h806,32'hCAFEF00D,1'b0,32'h0,32'h0,1'b0,1'b0},        // R8
    '{1'b1,3'd4,12'h807,32'h01234567,1'b0,32'h0,32'h0,1'b0,1'b0},        // R8
    '{1'b0,3'd4,12'h805,32'h0,1'b0,32'h0,32'hDEADBEEF,1'b0,1'b0},        // R8
    '{1'b0,3'd4,12'h806,32'h0,1'b0,32'h0,32'hCAFEF00D,1'b0,1'b0},        // R8
    '{1'b0,3'd4,12'h807,32'h0,1'b0,32'h0,32'h01234567,1'b0,1'b0},        // R8
    '{1'b1,3'd4,12'h803,32'h11110000,1'b1,32'h0,32'h0,1'b0,1'b1},        // R6 active MSP
    '{1'b0,3'd4,12'h803,32'h0,1'b0,32'hAAAA5555,32'h11110000,1'b0,1'b0}, // R7 stored MSP
    '{1'b0,3'd4,12'h803,32'h0,1'b1,32'hAAAA5555,32'hAAAA5555,1'b0,1'b0}, // R7 live
    '{1'b1,3'd4,12'h804,32'h22220000,1'b1,32'h0,32'h0,1'b0,1'b0},        // R6 inactive ISP
    '{1'b0,3'd4,12'h804,32'h0,1'b1,32'h0BAD0BAD,32'h22220000,1'b0,1'b0}, // R7 stored ISP
    '{1'b1,3'd4,12'h804,32'h33330000,1'b0,32'h0,32'h0,1'b0,1'b1},        // R6 active ISP
    '{1'b0,3'd4,12'h804,32'h0,1'b0,32'h0BAD0BAD,32'h0BAD0BAD,1'b0,1'b0}, // R7 live
    '{1'b0,3'd4,12'h804,32'h0,1'b1,32'h0BAD0BAD,32'h33330000,1'b0,1'b0}, // R7
    '{1'b1,3'd1,12'h002,32'hFFFFFFFF,1'b0,32'h0,32'h0,1'b1,1'b0},        // R9 R11 model 1
    '{1'b0,3'd4,12'h002,32'h0,1'b0,32'h0,32'h00000003,1'b0,1'b0},        // R11 unchanged
    '{1'b1,3'd4,12'h802,32'h00000000,1'b0,32'h0,32'h0,1'b1,1'b0},        // R9 model 4 cache addr
    '{1'b0,3'd5,12'h802,32'h0,1'b0,32'h0,32'h000000FC,1'b0,1'b0},        // R9 R11 model 5 legal
    '{1'b1,3'd4,12'h006,32'hFFFFFFFF,1'b0,32'h0,32'h0,1'b1,1'b0},        // R10
    '{1'b0,3'd4,12'h800,32'h0,1'b0,32'h0,32'h0,1'b1,1'b0},               // R10
    '{1'b1,3'd2,12'h803,32'h44440000,1'b1,32'h0,32'h0,1'b1,1'b0},        // R9 R11 no A7 load
    '{1'b0,3'd0,12'h001,32'h0,1'b0,32'h0,32'h5,1'b0,1'b0},               // R9 model 0
    '{1'b0,3'd1,12'h001,32'h0,1'b0,32'h0,32'h5,1'b0,1'b0},               // R9 model 1
    '{1'b0,3'd3,12'h003,32'h0,1'b0,32'h0,32'h0,1'b1,1'b0}                // R9 below 4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [2:0] model, input logic [11:0] num,
                        input logic [31:0] data, input logic master, input logic [31:0] a7);
    @(negedge clk);
    accEn = 1'b1; accWrite = wr; cpuModel = model; regNum = num;
    wrData = data; masterMode = master; a7Live = a7;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    accEn = 1'b0;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    access(1'b0, 3'd4, 12'h000, 32'h0, 1'b0, 32'h0); check("R1 sfc", rdData, 32'h0);
    access(1'b0, 3'd4, 12'h002, 32'h0, 1'b0, 32'h0); check("R1 cacr", rdData, 32'h0);
    access(1'b0, 3'd4, 12'h803, 32'h0, 1'b0, 32'h0); check("R1 msp", rdData, 32'h0);
    access(1'b0, 3'd4, 12'h806, 32'h0, 1'b0, 32'h0); check("R1 urp", rdData, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      access(v.wr, v.model, v.num, v.data, v.master, v.a7);
      total++;
      if (illegal !== v.expIll || rdData !== v.expRd || a7Load !== v.expLoad ||
          (v.expLoad && a7Value !== v.data)) begin
        bad++;
        $display("FAIL vector %0d (R2..R11) actual ill=%b rd=%h load=%b val=%h expected ill=%b rd=%h load=%b val=%h",
                 i, illegal, rdData, a7Load, a7Value, v.expIll, v.expRd, v.expLoad, v.data);
      end
    end

    // R12: no access, illegal number on the bus, write strobe set
    @(negedge clk);
    accEn = 1'b0; accWrite = 1'b1; regNum = 12'h803; masterMode = 1'b1; wrData = 32'h55555555;
    #2;
    check("R12 illegal idle", {31'b0, illegal}, 32'h0);
    check("R12 load idle", {31'b0, a7Load}, 32'h0);
    check("R12 rd idle", rdData, 32'h0);
    access(1'b0, 3'd4, 12'h803, 32'h0, 1'b0, 32'h0);
    check("R12 msp unchanged", rdData, 32'h11110000);

    // R1: reset mid-run clears stored values
    idle();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    access(1'b0, 3'd4, 12'h805, 32'h0, 1'b0, 32'h0); check("R1 mmusr after reset", rdData, 32'h0);
    access(1'b0, 3'd3, 12'h802, 32'h0, 1'b0, 32'h0); check("R1 caar after reset", rdData, 32'h0);
    idle();

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule